// File: doc/BRIEF.md
# Real-Time Clock Calendar Core

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each pulse on `sec_tick` advances the time by one second. Carries ripple up through the minutes, the hours, the days and the months. The length of each month is honoured, February gains a day in leap years, and the year wraps from 99 to 00. The values are stored and presented either as packed BCD or as plain binary. A control bit picks the encoding. Software writes the time in the encoding it has chosen, and the block does not convert values that are already stored.

All access goes through one indexed byte window. `reg_addr` selects a register, `reg_wr` writes `reg_wdata` into it, and `reg_rd` loads `reg_rdata` in the following cycle. The window covers the seven time fields, three alarm bytes, a control byte, a flag byte and fifty bytes of general-purpose storage. There are three event sources: update-done, alarm match and a periodic tick. Each one has its own flag and its own enable. `irq` is high while any flag is set together with its enable. Reading the flag byte clears all the flags.

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 1, date 1, month 1, year 00. The control byte reads 0x00, the flag byte reads 0x00 and `irq` is low.
- R2: Each `sec_tick` taken while the hold bit is clear advances the time by one second. Seconds roll over from 59 to 0 and carry into the minutes. Minutes roll over from 59 to 0 and carry into the hours. Hours roll over from 23 to 0 and carry into the day.
- R3: Control bit 0 picks the encoding. With the bit at 1, every time and alarm field is plain binary. With the bit at 0, a field is BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Register indices are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7/8/9 alarm seconds/minutes/hours, 10 control, 11 flags.
- R4: On a day carry, the weekday steps through 1..7 and wraps from 7 to 1. The date wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months except February. February has 29 days when the year value is divisible by 4 and 28 days otherwise.
- R5: On a carry out of month 12, the month returns to 1 and the year increments. The year wraps from 99 to 00.
- R6: While control bit 1 (hold) is set, ticks are ignored. The time fields keep their values and no update flag is raised. Clearing the bit makes the next tick count again.
- R7: One cycle after each counted tick, flag bit 4 (update) is set. In the same cycle, flag bit 5 (alarm) is set if the new seconds, minutes and hours match alarm bytes 7, 8 and 9. An alarm byte whose bits [7:6] are both 1 matches any value.
- R8: A clock edge at which `per_tick` is high sets flag bit 6 (periodic).
- R9: Reading index 11 returns the three flags in bits 6:4 and the `irq` level in bit 7, then clears the flags. A flag whose set event lands in the same cycle as that read is not included in the returned byte and stays set afterwards.
- R10: `irq` is high exactly while a flag is set whose enable bit is also set. The enable bits are control bits 4 (update), 5 (alarm) and 6 (periodic).
- R11: Indices 12 to 61 form 50 bytes of read/write storage. Indices 62 and 63 read as 0x00.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| per_tick | input | 1 | One-cycle periodic event pulse |
| reg_wr | input | 1 | Write strobe for the indexed window |
| reg_rd | input | 1 | Read strobe for the indexed window |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request level |

## Verification
A flag read can fall in the same cycle as an event that sets a flag: the read wants to clear every flag while the event wants to raise one. The bench raises `per_tick` in the very cycle it strobes a read of index 11. It then checks three things: the returned byte lacks the periodic bit, `irq` stays high afterwards, and a second read does report the flag. Alarm matches, with and without don't-care bytes, are checked in the same way on the cycle after the tick that produces them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int FIELD_W = 8;
    typedef logic [FIELD_W-1:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t date;
        byte_t month;
        byte_t year;
    } rtc_time_t;

    // register indices (decode order matters: time fields first, then alarm)
    localparam int IDX_YEAR  = 6;
    localparam int IDX_ASEC  = 7;
    localparam int IDX_AHOUR = 9;
    localparam int IDX_CTRL  = 10;
    localparam int IDX_FLAGS = 11;

    // control bits
    localparam int CB_BIN  = 0;
    localparam int CB_HOLD = 1;
    localparam int CB_EN_LO = 4;
    localparam int CB_EN_HI = 6;

    // flag vector positions (bit 0 update, bit 1 alarm, bit 2 periodic)
    localparam int NFLAGS = 3;

    function automatic byte_t bcd2bin(input byte_t v);
        return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    endfunction

    function automatic byte_t bin2bcd(input byte_t v);
        byte_t tens;
        byte_t units;
        tens  = v / 8'd10;
        units = v % 8'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic byte_t to_bin(input byte_t v, input logic bin_mode);
        return bin_mode ? v : bcd2bin(v);
    endfunction

    function automatic byte_t from_bin(input byte_t v, input logic bin_mode);
        return bin_mode ? v : bin2bcd(v);
    endfunction

    function automatic byte_t month_days(input byte_t mo, input byte_t yr);
        case (mo)
            8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       bin_mode,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  byte_t      wr_data,
    output rtc_time_t  time_o,
    output logic       upd_o
);
    typedef struct packed {
        rtc_time_t tm;
        logic      upd;
    } cal_state_t;

    localparam rtc_time_t TIME_RST = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                       wday: 8'd1, date: 8'd1, month: 8'd1,
                                       year: 8'd0};

    cal_state_t st_d, st_q;

    always_comb begin
        byte_t s, m, h, wd, dt, mo, yr;
        logic  cs, cm, ch, cd, cmo;
        st_d     = st_q;
        st_d.upd = 1'b0;
        s  = to_bin(st_q.tm.sec,   bin_mode);
        m  = to_bin(st_q.tm.min,   bin_mode);
        h  = to_bin(st_q.tm.hour,  bin_mode);
        wd = to_bin(st_q.tm.wday,  bin_mode);
        dt = to_bin(st_q.tm.date,  bin_mode);
        mo = to_bin(st_q.tm.month, bin_mode);
        yr = to_bin(st_q.tm.year,  bin_mode);
        cs  = (s  >= 8'd59);
        cm  = (m  >= 8'd59);
        ch  = (h  >= 8'd23);
        cd  = (dt >= month_days(mo, yr));
        cmo = (mo >= 8'd12);
        if (wr_en) begin
            // a software write wins; a tick in the same cycle is dropped
            case (wr_sel)
                3'd0: st_d.tm.sec   = wr_data;
                3'd1: st_d.tm.min   = wr_data;
                3'd2: st_d.tm.hour  = wr_data;
                3'd3: st_d.tm.wday  = wr_data;
                3'd4: st_d.tm.date  = wr_data;
                3'd5: st_d.tm.month = wr_data;
                3'd6: st_d.tm.year  = wr_data;
                default: ;
            endcase
        end else if (tick && !hold) begin
            st_d.upd = 1'b1;
            s = cs ? 8'd0 : s + 8'd1;
            if (cs) begin
                m = cm ? 8'd0 : m + 8'd1;
                if (cm) begin
                    h = ch ? 8'd0 : h + 8'd1;
                    if (ch) begin
                        wd = (wd >= 8'd7) ? 8'd1 : wd + 8'd1;
                        dt = cd ? 8'd1 : dt + 8'd1;
                        if (cd) begin
                            mo = cmo ? 8'd1 : mo + 8'd1;
                            if (cmo) yr = (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
                        end
                    end
                end
            end
            st_d.tm.sec   = from_bin(s,  bin_mode);
            st_d.tm.min   = from_bin(m,  bin_mode);
            st_d.tm.hour  = from_bin(h,  bin_mode);
            st_d.tm.wday  = from_bin(wd, bin_mode);
            st_d.tm.date  = from_bin(dt, bin_mode);
            st_d.tm.month = from_bin(mo, bin_mode);
            st_d.tm.year  = from_bin(yr, bin_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tm: TIME_RST, upd: 1'b0};
        else        st_q <= st_d;
    end

    assign time_o = st_q.tm;
    assign upd_o  = st_q.upd;

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en) |=> $stable(time_o));

    assert_upd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(tick && !hold && !wr_en));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  byte_t           wr_data,
    input  rtc_time_t       time_i,
    output logic [2:0][7:0] alarm_o,
    output logic            match_o
);
    typedef struct packed {
        logic [2:0][7:0] al;
    } alarm_state_t;

    alarm_state_t st_d, st_q;
    logic [2:0][7:0] cur;
    logic [2:0]      hit;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                2'd0: st_d.al[0] = wr_data;
                2'd1: st_d.al[1] = wr_data;
                2'd2: st_d.al[2] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = {time_i.hour, time_i.min, time_i.sec};

    for (genvar g = 0; g < 3; g++) begin : g_cmp
        // a byte with both top bits set is a wildcard
        assign hit[g] = (st_q.al[g][7:6] == 2'b11) || (st_q.al[g] == cur[g]);
    end

    assign match_o = &hit;
    assign alarm_o = st_q.al;
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              match_i,
    input  logic              per_i,
    input  logic              clr_i,
    input  logic [NFLAGS-1:0] en_i,
    output logic [NFLAGS-1:0] flags_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NFLAGS-1:0] flags;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NFLAGS-1:0] set_w;

    assign set_w = {per_i, upd_i & match_i, upd_i};

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flags = '0;
        // new events win over a clearing read in the same cycle
        st_d.flags = st_d.flags | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & en_i);

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_w == '0) |=> (flags_o == '0));

    assert_set_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_w) |=> ((flags_o & $past(set_w)) == $past(set_w)));

    assert_periodic_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        per_i |=> flags_o[2]);

    assert_alarm_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && match_i) |=> flags_o[1]);
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram
    import rtc_pkg::*;
#(
    parameter int DEPTH = 50,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  byte_t         wdata_i,
    input  logic [AW-1:0] raddr_i,
    output byte_t         rdata_o
);
    byte_t mem_d [DEPTH];
    byte_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i && (32'(waddr_i) < DEPTH)) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = (32'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;

    assert_ram_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (32'(waddr_i) < DEPTH)) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int RAM_DEPTH = 50,
    parameter int RAM_BASE  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              per_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam logic [ADDR_W-1:0] A_YEAR   = ADDR_W'(IDX_YEAR);
    localparam logic [ADDR_W-1:0] A_ASEC   = ADDR_W'(IDX_ASEC);
    localparam logic [ADDR_W-1:0] A_AHOUR  = ADDR_W'(IDX_AHOUR);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(IDX_FLAGS);
    localparam logic [ADDR_W-1:0] A_RAM_LO = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] A_RAM_HI = ADDR_W'(RAM_BASE + RAM_DEPTH);

    typedef struct packed {
        byte_t ctrl;
        byte_t rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              cal_wr, al_wr, ram_hit, ram_we, flags_clr, irq_w, upd_w, match_w;
    logic [1:0]        al_sel;
    logic [ADDR_W-1:0] al_off, ram_off;
    logic [RAM_AW-1:0] ram_idx;
    rtc_time_t         tm_w;
    logic [2:0][7:0]   al_w;
    logic [NFLAGS-1:0] flags_w;
    byte_t             ram_rd, rd_val;

    assign al_off    = reg_addr - A_ASEC;
    assign al_sel    = al_off[1:0];
    assign ram_off   = reg_addr - A_RAM_LO;
    assign ram_idx   = RAM_AW'(ram_off);
    assign cal_wr    = reg_wr && (reg_addr <= A_YEAR);
    assign al_wr     = reg_wr && (reg_addr >= A_ASEC) && (reg_addr <= A_AHOUR);
    assign ram_hit   = (reg_addr >= A_RAM_LO) && (reg_addr < A_RAM_HI);
    assign ram_we    = reg_wr && ram_hit;
    assign flags_clr = reg_rd && (reg_addr == A_FLAGS);

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .hold     (st_q.ctrl[CB_HOLD]),
        .bin_mode (st_q.ctrl[CB_BIN]),
        .wr_en    (cal_wr),
        .wr_sel   (reg_addr[2:0]),
        .wr_data  (reg_wdata),
        .time_o   (tm_w),
        .upd_o    (upd_w)
    );

    rtc_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (al_wr),
        .wr_sel  (al_sel),
        .wr_data (reg_wdata),
        .time_i  (tm_w),
        .alarm_o (al_w),
        .match_o (match_w)
    );

    rtc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd_w),
        .match_i (match_w),
        .per_i   (per_tick),
        .clr_i   (flags_clr),
        .en_i    (st_q.ctrl[CB_EN_HI:CB_EN_LO]),
        .flags_o (flags_w),
        .irq_o   (irq_w)
    );

    rtc_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .waddr_i (ram_idx),
        .wdata_i (reg_wdata),
        .raddr_i (ram_idx),
        .rdata_o (ram_rd)
    );

    always_comb begin
        rd_val = '0;
        if (reg_addr <= A_YEAR) begin
            case (reg_addr[2:0])
                3'd0: rd_val = tm_w.sec;
                3'd1: rd_val = tm_w.min;
                3'd2: rd_val = tm_w.hour;
                3'd3: rd_val = tm_w.wday;
                3'd4: rd_val = tm_w.date;
                3'd5: rd_val = tm_w.month;
                3'd6: rd_val = tm_w.year;
                default: rd_val = '0;
            endcase
        end else if (reg_addr <= A_AHOUR) begin
            case (al_sel)
                2'd0: rd_val = al_w[0];
                2'd1: rd_val = al_w[1];
                2'd2: rd_val = al_w[2];
                default: rd_val = '0;
            endcase
        end else if (reg_addr == A_CTRL) begin
            rd_val = st_q.ctrl;
        end else if (reg_addr == A_FLAGS) begin
            rd_val = {irq_w, flags_w, 4'b0000};
        end else if (ram_hit) begin
            rd_val = ram_rd;
        end
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && (reg_addr == A_CTRL)) st_d.ctrl = reg_wdata;
        if (reg_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = irq_w;

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       per_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    // reference model, binary
    int ms, mm, mh, mwd, md, mmo, my;
    logic [7:0] ctrl_v = 8'h00;

    always #10 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] enc(input int v);
        logic [3:0] t, u;
        t = 4'(v / 10);
        u = 4'(v % 10);
        return ctrl_v[0] ? 8'(v) : {t, u};
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mwd = (mwd == 7) ? 1 : mwd + 1;
                    md++;
                    if (md > mdays(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_v = v;
        wr(6'd10, v);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        if (!ctrl_v[1]) model_step();
    endtask

    task automatic ptick();
        @(negedge clk);
        per_tick = 1'b1;
        @(negedge clk);
        per_tick = 1'b0;
    endtask

    task automatic set_time(input int s, input int m, input int h, input int wd,
                            input int d, input int mo, input int y);
        logic [7:0] keep;
        keep = ctrl_v;
        wr_ctrl(keep | 8'h02);
        ms = s; mm = m; mh = h; mwd = wd; md = d; mmo = mo; my = y;
        wr(6'd0, enc(s)); wr(6'd1, enc(m)); wr(6'd2, enc(h)); wr(6'd3, enc(wd));
        wr(6'd4, enc(d)); wr(6'd5, enc(mo)); wr(6'd6, enc(y));
        wr_ctrl(keep);
    endtask

    task automatic check_time(input string req);
        logic [7:0] v;
        rd(6'd0, v); check(req, v, enc(ms));
        rd(6'd1, v); check(req, v, enc(mm));
        rd(6'd2, v); check(req, v, enc(mh));
        rd(6'd3, v); check(req, v, enc(mwd));
        rd(6'd4, v); check(req, v, enc(md));
        rd(6'd5, v); check(req, v, enc(mmo));
        rd(6'd6, v); check(req, v, enc(my));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] shadow [50];
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state (R12: every read below samples the cycle after the strobe)
        ms = 0; mm = 0; mh = 0; mwd = 1; md = 1; mmo = 1; my = 0;
        check_time("R1");
        rd(6'd10, v); check("R1 ctrl", v, 8'h00);
        rd(6'd11, v); check("R1 flags", v, 8'h00);
        check("R1 irq", irq, 0);

        // R3 encodings at the pins
        set_time(56, 34, 12, 2, 15, 6, 21);
        rd(6'd0, v); check("R3 bcd sec", v, 8'h56);
        wr_ctrl(8'h01);
        set_time(56, 34, 12, 2, 15, 6, 21);
        rd(6'd0, v); check("R3 bin sec", v, 8'h38);
        rd(6'd12, v); check("R12 hold after read", reg_rdata, v);

        // R2 second/minute/hour carries, BCD
        wr_ctrl(8'h00);
        set_time(58, 59, 23, 3, 15, 6, 21);
        tick(); tick();
        check_time("R2 day carry");

        // R4 month lengths and leap years, R4 weekday wrap
        set_time(59, 59, 23, 7, 28, 2, 24);
        tick(); check_time("R4 leap feb29");
        rd(6'd3, v); check("R4 weekday wrap", v, 8'h01);
        set_time(59, 59, 23, 1, 29, 2, 24);
        tick(); check_time("R4 leap to mar");
        set_time(59, 59, 23, 1, 28, 2, 23);
        tick(); check_time("R4 common feb");
        rd(6'd5, v); check("R4 common feb month", v, 8'h03);
        wr_ctrl(8'h01);
        set_time(59, 59, 23, 4, 30, 4, 50);
        tick(); check_time("R4 april end");

        // R5 century wrap
        wr_ctrl(8'h00);
        set_time(59, 59, 23, 5, 31, 12, 99);
        tick(); check_time("R5 year wrap");
        rd(6'd6, v); check("R5 year 00", v, 8'h00);

        // R6 hold
        wr_ctrl(8'h01);
        set_time(10, 10, 10, 1, 1, 1, 1);
        rd(6'd11, v);
        wr_ctrl(8'h03);
        tick(); tick(); tick();
        check_time("R6 frozen");
        rd(6'd11, v); check("R6 no update flag", v, 8'h00);
        wr_ctrl(8'h01);
        tick(); check_time("R6 resume");

        // R7 alarm with wildcards, exact match and mismatch
        wr_ctrl(8'h21);
        set_time(29, 20, 10, 1, 1, 1, 1);
        wr(6'd7, 8'd30); wr(6'd8, 8'hC0); wr(6'd9, 8'hC0);
        rd(6'd11, v);
        tick();
        @(negedge clk); check("R7 irq after alarm", irq, 1);
        rd(6'd11, v); check("R7 wildcard match", v, 8'hB0);
        check("R9 irq after clear", irq, 0);
        wr(6'd7, 8'd45); wr(6'd8, 8'd20); wr(6'd9, 8'd10);
        tick();
        rd(6'd11, v); check("R7 mismatch update only", v, 8'h10);
        wr(6'd7, 8'd32);
        tick();
        rd(6'd11, v); check("R7 exact match", v, 8'hB0);

        // R8 periodic flag, R10 gating by enable
        wr_ctrl(8'h01);
        rd(6'd11, v);
        ptick();
        check("R10 irq masked", irq, 0);
        wr_ctrl(8'h41);
        @(negedge clk); check("R10 irq enabled", irq, 1);
        rd(6'd11, v); check("R8 periodic flag", v, 8'hC0);
        check("R10 irq low after clear", irq, 0);

        // R9 read-clear colliding with a new periodic event
        @(negedge clk);
        per_tick = 1'b1; reg_rd = 1'b1; reg_addr = 6'd11;
        @(negedge clk);
        per_tick = 1'b0; reg_rd = 1'b0;
        check("R9 collision read value", reg_rdata, 8'h00);
        check("R9 flag kept irq", irq, 1);
        rd(6'd11, v); check("R9 kept flag reported", v, 8'hC0);
        rd(6'd11, v); check("R9 cleared", v, 8'h00);

        // R11 storage
        for (int i = 0; i < 50; i++) begin
            shadow[i] = 8'($urandom);
            wr(6'(12 + i), shadow[i]);
        end
        for (int i = 0; i < 50; i++) begin
            rd(6'(12 + i), v); check("R11 ram", v, shadow[i]);
        end
        wr(6'd62, 8'hAA); rd(6'd62, v); check("R11 idx62", v, 8'h00);
        wr(6'd63, 8'h55); rd(6'd63, v); check("R11 idx63", v, 8'h00);

        // random runs for R2, R3, R4, R5
        for (int it = 0; it < 20; it++) begin
            int y, mo, d, h, m, s, wd, n;
            wr_ctrl(8'($urandom % 2));
            y  = $urandom % 100;
            mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
            d  = ($urandom % 2 == 0) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
            h  = ($urandom % 2 == 0) ? 23 : $urandom % 24;
            m  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
            s  = $urandom % 60;
            wd = 1 + $urandom % 7;
            set_time(s, m, h, wd, d, mo, y);
            n = $urandom % 150;
            for (int k = 0; k < n; k++) tick();
            check_time("R2 R4 R5 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule